// File: doc/BRIEF.md
# Status Packet Generator

This block turns a parallel status word into a short byte-serial packet for a status collection network that several sources share. When a packet is due it raises a request and drives the destination address byte. After the network acknowledges that address byte, it drives the payload bytes on consecutive cycles. The first payload byte carries a 6-bit sequence number together with the two lowest status bits. The bytes after it carry the remaining status bits in groups of eight, starting with the least significant group.

Software programs the block through a one-byte write port. The write selects when packets are produced and sets the sequence number. A packet can be produced once per write, on every change of the status word, or both. The status word and the sequence number are frozen when the request rises. Every packet is therefore self-consistent, however much the inputs move while it waits for the acknowledge or while it is being sent.

Top module: `stat_pkt_gen`

## Requirements
- R1: After reset `pkt_req` is 0, `pkt_byte` is 0 and the reporting mode is off, so status changes produce no packet.
- R2: A write uses `cfg_wdata[7:6]` as the mode (0 off, 1 single, 2 on change, 3 single plus on change) and `cfg_wdata[5:0]` as the sequence number. Writing mode 1 or 3 schedules one packet. With the transmitter idle, `pkt_req` is high after the second rising edge counted from the edge that samples the write.
- R3: While `pkt_req` is high, `pkt_byte` equals the address parameter (default 0x21). `pkt_req` stays high until `pkt_start` is sampled high.
- R4: At the edge that samples `pkt_start` high while `pkt_req` is high, `pkt_req` falls. The payload bytes then appear on consecutive cycles: `{seq[5:0], status[1:0]}`, then status[9:2], status[17:10] and status[25:18]. Bits above the payload width are zero. The number of payload bytes is 1 + ceil((PAYLOAD_BITS-2)/8), which is 3 for the default width of 15.
- R5: `pkt_byte` is 0 whenever the block is neither requesting nor sending. `pkt_start` has no effect while `pkt_req` is low.
- R6: The status word and the sequence number are captured at the edge where `pkt_req` rises. Later changes to either do not alter that packet.
- R7: In modes 2 and 3, a status value that differs from its value one cycle earlier schedules a packet. With the transmitter idle, `pkt_req` is high after the second edge counted from the first edge that samples the new value.
- R8: Any number of status changes while a packet is requested or sent schedule exactly one further packet, which follows the current one.
- R9: In modes 0 and 1, status changes are ignored. Writing mode 0 cancels a scheduled packet that has not yet raised `pkt_req`, including one scheduled in the same cycle.
- R10: After the last payload byte the block spends exactly one cycle idle, with `pkt_byte` 0 and `pkt_req` low, before it raises the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte: mode in [7:6], sequence number in [5:0] |
| status | input | PAYLOAD_BITS | Parallel status word to report |
| pkt_start | input | 1 | Acknowledge of the address byte |
| pkt_req | output | 1 | Request to send a packet |
| pkt_byte | output | 8 | Packet byte, zero when idle |

## Verification
Each internal state of this block reaches the ports within a few cycles. A scheduled-packet flag that is lost or stuck shows up as a missing or surplus request two edges after the triggering write or change. An overlap of several changes that is counted wrongly shows up as a second surplus packet right after the one-cycle gap. A snapshot taken at the wrong edge, or one that is not held, shows up as a wrong payload byte in the packet itself. A byte index that runs off by one shows up as a wrong byte value or a non-zero byte in the idle cycle that follows the packet.

// File: rtl/stat_pkt_pkg.sv
package stat_pkt_pkg;

    localparam int SEQ_W = 6;

    typedef enum logic [1:0] {
        MODE_OFF        = 2'd0,
        MODE_SINGLE     = 2'd1,
        MODE_ON_CHANGE  = 2'd2,
        MODE_SINGLE_CHG = 2'd3
    } report_mode_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_REQ  = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    // payload bytes: one for {seq, two status bits}, then the rest of the status in bytes
    function automatic int payload_bytes(input int pbits);
        return 1 + (pbits - 2 + 7) / 8;
    endfunction

    function automatic logic tracks_change(input report_mode_e m);
        return (m == MODE_ON_CHANGE) || (m == MODE_SINGLE_CHG);
    endfunction

    function automatic logic fires_on_write(input report_mode_e m);
        return (m == MODE_SINGLE) || (m == MODE_SINGLE_CHG);
    endfunction

endpackage

// File: rtl/stat_pkt_watch.sv
module stat_pkt_watch #(
    parameter int PAYLOAD_BITS = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PAYLOAD_BITS-1:0] status,
    output logic                    change
);

    typedef struct packed {
        logic [PAYLOAD_BITS-1:0] prev;
    } watch_t;

    watch_t watch_d, watch_q;

    always_comb begin
        watch_d      = watch_q;
        watch_d.prev = status;
    end

    always_ff @(posedge clk) begin
        if (rst) watch_q <= '0;
        else     watch_q <= watch_d;
    end

    assign change = (status != watch_q.prev);

endmodule

// File: rtl/stat_pkt_ctrl.sv
module stat_pkt_ctrl
    import stat_pkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             change,
    input  logic             launch,
    output report_mode_e     mode,
    output logic [SEQ_W-1:0] seq,
    output logic             pending
);

    typedef struct packed {
        report_mode_e     mode;
        logic [SEQ_W-1:0] seq;
        logic             pending;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{mode: MODE_OFF, seq: '0, pending: 1'b0};

    ctrl_t ctrl_d, ctrl_q;
    report_mode_e wr_mode;

    assign wr_mode = report_mode_e'(cfg_wdata[7:6]);

    always_comb begin
        ctrl_d = ctrl_q;
        if (launch) ctrl_d.pending = 1'b0;
        if (change && tracks_change(ctrl_q.mode)) ctrl_d.pending = 1'b1;
        if (cfg_we) begin
            ctrl_d.mode = wr_mode;
            ctrl_d.seq  = cfg_wdata[SEQ_W-1:0];
            if (wr_mode == MODE_OFF)       ctrl_d.pending = 1'b0;
            else if (fires_on_write(wr_mode)) ctrl_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_RST;
        else     ctrl_q <= ctrl_d;
    end

    assign mode    = ctrl_q.mode;
    assign seq     = ctrl_q.seq;
    assign pending = ctrl_q.pending;

    // R9
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[7:6] == 2'd0) |=> !pending);

    // R7
    change_sched_chk: assert property (@(posedge clk) disable iff (rst)
        (change && tracks_change(mode) && !cfg_we) |=> pending);

endmodule

// File: rtl/stat_pkt_tx.sv
module stat_pkt_tx
    import stat_pkt_pkg::*;
#(
    parameter int          PAYLOAD_BITS = 15,
    parameter logic [7:0]  ADDR_BYTE    = 8'h21
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pending,
    input  logic [PAYLOAD_BITS-1:0] status,
    input  logic [SEQ_W-1:0]        seq,
    input  logic                    pkt_start,
    output logic                    launch,
    output logic                    pkt_req,
    output logic [7:0]              pkt_byte
);

    localparam int NPB     = payload_bytes(PAYLOAD_BITS);
    localparam int FRAME_W = 8 * NPB;
    localparam int USED_W  = PAYLOAD_BITS + SEQ_W;
    localparam int IDX_W   = (NPB > 1) ? $clog2(NPB) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPB - 1);

    typedef struct packed {
        tx_state_e          state;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] frame;
    } tx_t;

    localparam tx_t TX_RST = '{state: TX_IDLE, idx: '0, frame: '0};

    tx_t tx_d, tx_q;
    logic [FRAME_W-1:0] frame_now;

    // frame layout: [1:0] low status bits, [7:2] sequence, then status[PB-1:2]
    assign frame_now[1:0]       = status[1:0];
    assign frame_now[7:2]       = seq;
    for (genvar b = 2; b < PAYLOAD_BITS; b++) begin : g_status_bit
        assign frame_now[b + SEQ_W] = status[b];
    end
    if (FRAME_W > USED_W) begin : g_pad
        assign frame_now[FRAME_W-1:USED_W] = '0;
    end

    assign launch = (tx_q.state == TX_IDLE) && pending;

    always_comb begin
        tx_d = tx_q;
        unique case (tx_q.state)
            TX_IDLE: begin
                if (pending) begin
                    tx_d.state = TX_REQ;
                    tx_d.frame = frame_now;
                end
            end
            TX_REQ: begin
                if (pkt_start) begin
                    tx_d.state = TX_SEND;
                    tx_d.idx   = '0;
                end
            end
            TX_SEND: begin
                if (tx_q.idx == LAST_IDX) begin
                    tx_d.state = TX_IDLE;
                    tx_d.idx   = '0;
                end else begin
                    tx_d.idx = tx_q.idx + 1'b1;
                end
            end
            default: tx_d = TX_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tx_q <= TX_RST;
        else     tx_q <= tx_d;
    end

    always_comb begin
        pkt_byte = 8'h00;
        if (tx_q.state == TX_REQ)       pkt_byte = ADDR_BYTE;
        else if (tx_q.state == TX_SEND) pkt_byte = tx_q.frame[{tx_q.idx, 3'b000} +: 8];
    end

    assign pkt_req = (tx_q.state == TX_REQ);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_req && !pkt_start) |=> pkt_req);

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_req && pkt_start) |=> (!pkt_req && tx_q.state == TX_SEND));

    // R6
    snap_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_q.state == TX_SEND) |-> $stable(tx_q.frame));

    // R10
    gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_q.state == TX_SEND && tx_q.idx == LAST_IDX) |=> (!pkt_req && pkt_byte == 8'h00));

endmodule

// File: rtl/stat_pkt_gen.sv
module stat_pkt_gen
    import stat_pkt_pkg::*;
#(
    parameter int         PAYLOAD_BITS = 15,
    parameter logic [7:0] ADDR_BYTE    = 8'h21
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [7:0]              cfg_wdata,
    input  logic [PAYLOAD_BITS-1:0] status,
    input  logic                    pkt_start,
    output logic                    pkt_req,
    output logic [7:0]              pkt_byte
);

    logic             change;
    logic             launch;
    logic             pending;
    report_mode_e     mode;
    logic [SEQ_W-1:0] seq;

    stat_pkt_watch #(
        .PAYLOAD_BITS (PAYLOAD_BITS)
    ) watch_i (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .change (change)
    );

    stat_pkt_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .change    (change),
        .launch    (launch),
        .mode      (mode),
        .seq       (seq),
        .pending   (pending)
    );

    stat_pkt_tx #(
        .PAYLOAD_BITS (PAYLOAD_BITS),
        .ADDR_BYTE    (ADDR_BYTE)
    ) tx_i (
        .clk       (clk),
        .rst       (rst),
        .pending   (pending),
        .status    (status),
        .seq       (seq),
        .pkt_start (pkt_start),
        .launch    (launch),
        .pkt_req   (pkt_req),
        .pkt_byte  (pkt_byte)
    );

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        rst |=> (!pkt_req && pkt_byte == 8'h00 && mode == MODE_OFF));

endmodule

// File: tb/stat_pkt_gen_tb_top.sv
`timescale 1ns/1ps
module stat_pkt_gen_tb_top;

    localparam int         PB   = 15;
    localparam int         NPB  = 1 + (PB - 2 + 7) / 8;
    localparam logic [7:0] ADDR = 8'h21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = 8'h00;
    logic [PB-1:0] status = '0;
    logic          pkt_start = 1'b0;
    logic          pkt_req;
    logic [7:0]    pkt_byte;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    stat_pkt_gen #(
        .PAYLOAD_BITS (PB),
        .ADDR_BYTE    (ADDR)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .status    (status),
        .pkt_start (pkt_start),
        .pkt_req   (pkt_req),
        .pkt_byte  (pkt_byte)
    );

    function automatic logic [7:0] exp_byte(input logic [PB-1:0] st, input logic [5:0] sq, input int i);
        logic [8*NPB-1:0] f;
        f = '0;
        f[1:0] = st[1:0];
        f[7:2] = sq;
        for (int b = 2; b < PB; b++) f[b + 6] = st[b];
        return f[8*i +: 8];
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [1:0] m, input logic [5:0] sq);
        cfg_we    = 1'b1;
        cfg_wdata = {m, sq};
        step();
        cfg_we    = 1'b0;
    endtask

    task automatic new_status();
        logic [PB-1:0] v;
        v = PB'($urandom);
        if (v == status) v = ~v;
        status = v;
    endtask

    // entered at a negedge with the request expected high
    task automatic recv(input logic [PB-1:0] est, input logic [5:0] esq, input int dly,
                        input bit mutate, input string tag);
        chk(pkt_req === 1'b1, {"R3 req ", tag}, 32'(pkt_req), 1);
        chk(pkt_byte === ADDR, {"R3 addr ", tag}, 32'(pkt_byte), 32'(ADDR));
        for (int i = 0; i < dly; i++) begin
            if (mutate) new_status();
            step();
            chk(pkt_req === 1'b1, {"R3 hold ", tag}, 32'(pkt_req), 1);
            chk(pkt_byte === ADDR, {"R3 hold addr ", tag}, 32'(pkt_byte), 32'(ADDR));
        end
        pkt_start = 1'b1;
        step();
        pkt_start = 1'b0;
        for (int i = 0; i < NPB; i++) begin
            chk(pkt_req === 1'b0, {"R4 req low ", tag}, 32'(pkt_req), 0);
            chk(pkt_byte === exp_byte(est, esq, i), {"R4 R6 payload ", tag},
                32'(pkt_byte), 32'(exp_byte(est, esq, i)));
            if (mutate && i == 0) new_status();
            step();
        end
        chk(pkt_byte === 8'h00 && pkt_req === 1'b0, {"R5 R10 gap ", tag},
            {23'd0, pkt_req, pkt_byte}, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [PB-1:0] snap;
        logic [5:0]    sq;
        void'($urandom(32'd4242));
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;

        // R1: reset state, changes ignored while off
        chk(pkt_req === 1'b0 && pkt_byte === 8'h00, "R1 reset", {23'd0, pkt_req, pkt_byte}, 0);
        new_status(); step(); step(); step();
        chk(pkt_req === 1'b0, "R1 off ignores change", 32'(pkt_req), 0);

        // R5: start ignored while idle
        pkt_start = 1'b1; step(); step(); pkt_start = 1'b0;
        chk(pkt_byte === 8'h00 && pkt_req === 1'b0, "R5 start while idle", {23'd0, pkt_req, pkt_byte}, 0);

        // R2: single mode, request two edges after the write edge
        write_cfg(2'd1, 6'd5);
        chk(pkt_req === 1'b0, "R2 one edge after write", 32'(pkt_req), 0);
        snap = status;
        step();
        chk(pkt_req === 1'b1, "R2 request raised", 32'(pkt_req), 1);
        // R6, R9: status churn during request is ignored in single mode
        recv(snap, 6'd5, 3, 1'b1, "single");
        repeat (4) begin
            step();
            chk(pkt_req === 1'b0, "R9 single mode ignores change", 32'(pkt_req), 0);
        end

        // R7: on-change mode
        write_cfg(2'd2, 6'd9);
        step();
        chk(pkt_req === 1'b0, "R7 write of mode 2 sends nothing", 32'(pkt_req), 0);
        new_status(); snap = status;
        step();
        chk(pkt_req === 1'b0, "R7 first edge", 32'(pkt_req), 0);
        step();
        chk(pkt_req === 1'b1, "R7 second edge", 32'(pkt_req), 1);
        // R8: changes during the packet give exactly one follow-up
        recv(snap, 6'd9, 3, 1'b1, "changing");
        snap = status;
        step();
        chk(pkt_req === 1'b1, "R10 R8 follow-up after one idle cycle", 32'(pkt_req), 1);
        recv(snap, 6'd9, 1, 1'b0, "follow-up");
        repeat (5) begin
            step();
            chk(pkt_req === 1'b0, "R8 only one follow-up", 32'(pkt_req), 0);
        end

        // R9 + R6: cancel a follow-up scheduled during request; new seq not in packet
        new_status(); snap = status;
        step(); step();
        chk(pkt_req === 1'b1, "R7 request before cancel", 32'(pkt_req), 1);
        new_status();
        step();
        write_cfg(2'd0, 6'd33);
        recv(snap, 6'd9, 0, 1'b0, "cancel");
        repeat (4) begin
            step();
            chk(pkt_req === 1'b0, "R9 cancelled follow-up", 32'(pkt_req), 0);
        end

        // R9: cancel in the same cycle as a change
        write_cfg(2'd2, 6'd12);
        new_status();
        cfg_we = 1'b1; cfg_wdata = {2'd0, 6'd12};
        step();
        cfg_we = 1'b0;
        repeat (4) begin
            step();
            chk(pkt_req === 1'b0, "R9 same-cycle cancel", 32'(pkt_req), 0);
        end

        // R2 + R7: mode 3 fires on write and on change
        write_cfg(2'd3, 6'd63);
        snap = status;
        step();
        chk(pkt_req === 1'b1, "R2 mode 3 write", 32'(pkt_req), 1);
        recv(snap, 6'd63, 1, 1'b0, "mode3 write");
        new_status(); snap = status;
        step(); step();
        chk(pkt_req === 1'b1, "R7 mode 3 change", 32'(pkt_req), 1);
        recv(snap, 6'd63, 2, 1'b0, "mode3 change");

        // random phase in on-change mode
        write_cfg(2'd2, 6'd1);
        sq = 6'd1;
        for (int it = 0; it < 60; it++) begin
            if ($urandom_range(0, 1) == 1) begin
                sq = 6'($urandom);
                write_cfg(2'd2, sq);
                chk(pkt_req === 1'b0, "R2 mode 2 write silent", 32'(pkt_req), 0);
            end
            for (int w = 0; w < int'($urandom_range(0, 3)); w++) begin
                step();
                chk(pkt_req === 1'b0, "R7 no change no packet", 32'(pkt_req), 0);
            end
            new_status(); snap = status;
            step();
            chk(pkt_req === 1'b0, "R7 random first edge", 32'(pkt_req), 0);
            step();
            chk(pkt_req === 1'b1, "R7 random second edge", 32'(pkt_req), 1);
            recv(snap, sq, int'($urandom_range(0, 4)), 1'b0, "random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule